// File: doc/BRIEF.md
# Serial NOR Flash Word-Burst Write Sequencer

This block writes a run of bytes from a streaming source into a serial NOR flash over a mode-0 SPI link with no processor involvement. The caller supplies a start address and a byte count with a one-cycle start pulse. The block then pulls data bytes through a ready/valid handshake and issues the flash commands needed to program them. When the work is finished, or has been refused or abandoned, it pulses `done`.

Most of the data goes through the flash's auto-incrementing two-byte program mode. The first frame of a burst carries the target address. Every later frame carries only the opcode and two data bytes, and the flash advances its own address. A byte at an odd start address and a single leftover byte at the end are each written with a separate one-byte program command that carries the full address.

Before every command, and before it reports completion, the block reads the status register until the busy bit is clear. A bounded number of busy replies abandons the request. Chip select is released between any two commands.

Top module: `aai_flash_writer`

## Requirements
- R1: A start with length 0 pulses `done` with `err` low and `bytes_written` 0, and produces no SPI frame.
- R2: A start whose address plus length exceeds `DEV_BYTES` pulses `done` with `err` high and produces no SPI frame; a request ending exactly at `DEV_BYTES` is accepted.
- R3: The command opcodes are 0x06 write enable, 0x04 write disable, 0x02 single-byte program, 0xAD word program and 0x05 status read. A status read is one opcode byte followed by one byte returned on MISO, of which bit 0 is the busy flag. No command frame starts while the flash would report busy.
- R4: The first command after a start is write enable. If the start address is odd, the next command is a single-byte program of the first data byte: opcode, three address bytes sent most significant first, then the data byte.
- R5: The first word-program frame of a burst is opcode, three address bytes and two data bytes. Each later word-program frame is the opcode followed by the next two data bytes.
- R6: After the last full word, or after a leading byte with no word following it, the block sends write disable, then waits for the busy bit to clear before continuing or finishing.
- R7: A single leftover byte is written as write enable, then a single-byte program carrying that byte's full address, then write disable.
- R8: If `POLL_LIMIT` consecutive status reads all report busy, the block pulses `done` with `err` high, leaves chip select high and returns to idle.
- R9: When `done` pulses, `bytes_written` equals the number of data bytes sent inside program frames.
- R10: SPI runs in mode 0: the clock is low whenever chip select is high, and MOSI changes only while the clock is low.
- R11: Data bytes are consumed in stream order, each reaching the flash address `start_addr` plus its index. `wr_ready` is only high while the block is busy and no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse, taken while idle |
| start_addr | input | 24 | First flash byte address |
| length | input | LEN_W | Number of bytes to write |
| wr_data | input | 8 | Data byte from the stream |
| wr_valid | input | 1 | `wr_data` is valid |
| wr_ready | output | 1 | Block takes `wr_data` on this edge when valid |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Qualifies `done`: rejected or timed out |
| bytes_written | output | LEN_W | Data bytes programmed, valid with `done` |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Requests are tried with even and odd start addresses and with lengths of one, odd and even. This separates the leading-byte path, the pure word burst, the trailing-byte path and the case where both single-byte paths appear around a burst. Zero length and a range that overruns the device by one byte are each compared with a range that ends exactly at the device boundary. A flash model that never clears its busy flag shows whether the poll bound counts exact replies. A model that stays busy for a few reads after every program command shows whether any command slips out before the flash is ready.

// File: rtl/aai_wr_pkg.sv
package aai_wr_pkg;
  localparam int ADDR_BYTES = 3;
  localparam int ADDR_W     = 8 * ADDR_BYTES;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_BYTE = 8'h02;
  localparam logic [7:0] OPC_WORD = 8'hAD;

  typedef enum logic [2:0] {OP_WREN, OP_BYTE, OP_WORD, OP_WRDI, OP_FINISH} op_e;
  typedef enum logic [2:0] {ST_IDLE, ST_POLL, ST_PGAP, ST_FETCH, ST_CMD, ST_CGAP} st_e;

  // bytes on the wire for one command frame
  function automatic logic [2:0] frame_bytes(op_e op, logic burst_on);
    case (op)
      OP_BYTE: return 3'd5;
      OP_WORD: return burst_on ? 3'd3 : 3'd6;
      default: return 3'd1;
    endcase
  endfunction

  // data bytes carried by one command frame
  function automatic logic [1:0] data_bytes(op_e op);
    case (op)
      OP_BYTE: return 2'd1;
      OP_WORD: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic in_range(logic [31:0] base, logic [31:0] count, logic [31:0] size);
    return ({1'b0, base} + {1'b0, count}) <= {1'b0, size};
  endfunction

  // command order after one command has finished, given post-update position
  function automatic op_e after_op(op_e op, logic tail, logic addr_odd,
                                   logic two_left, logic one_left);
    case (op)
      OP_WREN: return (tail || addr_odd) ? OP_BYTE : (two_left ? OP_WORD : OP_WRDI);
      OP_BYTE: return (!tail && two_left) ? OP_WORD : OP_WRDI;
      OP_WORD: return two_left ? OP_WORD : OP_WRDI;
      OP_WRDI: return (!tail && one_left) ? OP_WREN : OP_FINISH;
      default: return OP_FINISH;
    endcase
  endfunction
endpackage

// File: rtl/aai_spi_byte.sv
module aai_spi_byte #(
  parameter int SCK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  output logic       rx_lsb,
  output logic       active,
  output logic       byte_done,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int DW = $clog2(SCK_DIV + 1);

  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic          samp_q, sclk_q, act_q, done_q;
  logic          tick;

  assign tick = act_q && (div_q == DW'(SCK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; bit_q <= '0; sh_q <= '0;
      samp_q <= 1'b0; sclk_q <= 1'b0; act_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (go) begin
          act_q <= 1'b1; sh_q <= tx; bit_q <= '0; div_q <= '0; sclk_q <= 1'b0;
        end
      end else if (tick) begin
        div_q  <= '0;
        sclk_q <= ~sclk_q;
        if (!sclk_q) begin
          samp_q <= miso;
        end else begin
          sh_q  <= {sh_q[6:0], samp_q};
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  assign mosi      = sh_q[7];
  assign sclk      = sclk_q;
  assign rx_lsb    = sh_q[0];
  assign active    = act_q;
  assign byte_done = done_q;

  AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(sh_q[7])); // R10
endmodule

// File: rtl/aai_seq.sv
module aai_seq
  import aai_wr_pkg::*;
#(
  parameter int          LEN_W      = 16,
  parameter logic [31:0] DEV_BYTES  = 32'h0010_0000,
  parameter int          POLL_LIMIT = 200,
  parameter int          CS_GAP     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  length,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [LEN_W-1:0]  bytes_written,
  output logic              eng_go,
  output logic [7:0]        eng_tx,
  input  logic              eng_status,
  input  logic              eng_active,
  input  logic              eng_done,
  output logic              cs_n
);
  localparam int GW = $clog2(CS_GAP + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);

  st_e               st_q;
  op_e               op_q, op_nxt;
  logic              tail_q, aai_q, launch_q, stat_q, done_q, err_q;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [LEN_W-1:0]  rem_q, len_q, wrote_q, rem_n, step;
  logic [7:0]        d0_q, d1_q;
  logic [1:0]        fcnt_q;
  logic [2:0]        bidx_q;
  logic [GW-1:0]     gap_q;
  logic [PW-1:0]     polls_q;
  logic              gap_end, last_byte;

  // position after the command in flight completes
  assign step    = LEN_W'(data_bytes(op_q));
  assign rem_n   = rem_q - step;
  assign addr_n  = addr_q + ADDR_W'(step);
  assign op_nxt  = after_op(op_q, tail_q, addr_n[0], rem_n >= LEN_W'(2), rem_n == LEN_W'(1));
  assign gap_end = gap_q == GW'(CS_GAP - 1);
  assign last_byte = (st_q == ST_POLL) ? (bidx_q == 3'd1)
                                       : (bidx_q == frame_bytes(op_q, aai_q) - 3'd1);

  assign cs_n     = !(st_q == ST_POLL || st_q == ST_CMD);
  assign eng_go   = launch_q && !eng_active;
  assign wr_ready = (st_q == ST_FETCH) && (fcnt_q < data_bytes(op_q));
  assign busy     = st_q != ST_IDLE;
  assign done     = done_q;
  assign err      = err_q;
  assign bytes_written = wrote_q;

  always_comb begin
    eng_tx = 8'h00;
    if (st_q == ST_POLL) begin
      eng_tx = (bidx_q == 3'd0) ? OPC_RDSR : 8'h00;
    end else begin
      case (op_q)
        OP_WREN: eng_tx = OPC_WREN;
        OP_WRDI: eng_tx = OPC_WRDI;
        OP_BYTE: case (bidx_q)
          3'd0:    eng_tx = OPC_BYTE;
          3'd1:    eng_tx = addr_q[23:16];
          3'd2:    eng_tx = addr_q[15:8];
          3'd3:    eng_tx = addr_q[7:0];
          default: eng_tx = d0_q;
        endcase
        OP_WORD: if (aai_q) begin
          case (bidx_q)
            3'd0:    eng_tx = OPC_WORD;
            3'd1:    eng_tx = d0_q;
            default: eng_tx = d1_q;
          endcase
        end else begin
          case (bidx_q)
            3'd0:    eng_tx = OPC_WORD;
            3'd1:    eng_tx = addr_q[23:16];
            3'd2:    eng_tx = addr_q[15:8];
            3'd3:    eng_tx = addr_q[7:0];
            3'd4:    eng_tx = d0_q;
            default: eng_tx = d1_q;
          endcase
        end
        default: eng_tx = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; op_q <= OP_WREN; tail_q <= 1'b0; aai_q <= 1'b0;
      launch_q <= 1'b0; stat_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      addr_q <= '0; rem_q <= '0; len_q <= '0; wrote_q <= '0;
      d0_q <= '0; d1_q <= '0; fcnt_q <= '0; bidx_q <= '0; gap_q <= '0; polls_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (eng_go) launch_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) begin
          len_q <= length; rem_q <= length; addr_q <= start_addr; wrote_q <= '0;
          tail_q <= 1'b0; aai_q <= 1'b0; polls_q <= '0;
          if (length == '0) begin
            done_q <= 1'b1;
          end else if (!in_range(32'(start_addr), 32'(length), DEV_BYTES)) begin
            done_q <= 1'b1; err_q <= 1'b1;
          end else begin
            op_q <= OP_WREN; st_q <= ST_POLL; bidx_q <= '0; launch_q <= 1'b1;
          end
        end
        ST_POLL: if (eng_done) begin
          if (last_byte) begin
            stat_q <= eng_status; st_q <= ST_PGAP; gap_q <= '0;
          end else begin
            bidx_q <= bidx_q + 3'd1; launch_q <= 1'b1;
          end
        end
        ST_PGAP: if (!gap_end) begin
          gap_q <= gap_q + GW'(1);
        end else if (stat_q) begin
          if (polls_q == PW'(POLL_LIMIT - 1)) begin
            done_q <= 1'b1; err_q <= 1'b1; st_q <= ST_IDLE;
          end else begin
            polls_q <= polls_q + PW'(1); st_q <= ST_POLL; bidx_q <= '0; launch_q <= 1'b1;
          end
        end else begin
          polls_q <= '0;
          if (op_q == OP_FINISH) begin
            done_q <= 1'b1; st_q <= ST_IDLE;
          end else begin
            st_q <= ST_FETCH; fcnt_q <= '0;
          end
        end
        ST_FETCH: if (fcnt_q == data_bytes(op_q)) begin
          st_q <= ST_CMD; bidx_q <= '0; launch_q <= 1'b1;
        end else if (wr_valid) begin
          if (fcnt_q == 2'd0) d0_q <= wr_data;
          else                d1_q <= wr_data;
          fcnt_q <= fcnt_q + 2'd1;
        end
        ST_CMD: if (eng_done) begin
          if (last_byte) begin
            rem_q <= rem_n; addr_q <= addr_n; wrote_q <= wrote_q + step;
            if (op_q == OP_WORD) aai_q <= 1'b1;
            if (op_q == OP_WRDI) aai_q <= 1'b0;
            if (op_q == OP_WRDI && op_nxt == OP_WREN) tail_q <= 1'b1;
            op_q <= op_nxt; st_q <= ST_CGAP; gap_q <= '0;
          end else begin
            bidx_q <= bidx_q + 3'd1; launch_q <= 1'b1;
          end
        end
        ST_CGAP: if (!gap_end) begin
          gap_q <= gap_q + GW'(1);
        end else begin
          st_q <= ST_POLL; bidx_q <= '0; launch_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_BYTE_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, wrote_q} + {1'b0, rem_q}) == {1'b0, len_q}); // R9
  AST_POLL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    polls_q < PW'(POLL_LIMIT)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R1
endmodule

// File: rtl/aai_flash_writer.sv
module aai_flash_writer
  import aai_wr_pkg::*;
#(
  parameter int          LEN_W      = 16,
  parameter logic [31:0] DEV_BYTES  = 32'h0010_0000,
  parameter int          SCK_DIV    = 2,
  parameter int          POLL_LIMIT = 200,
  parameter int          CS_GAP     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  length,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [LEN_W-1:0]  bytes_written,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic       eng_go, eng_status, eng_active, eng_done;
  logic [7:0] eng_tx;

  aai_seq #(
    .LEN_W(LEN_W), .DEV_BYTES(DEV_BYTES), .POLL_LIMIT(POLL_LIMIT), .CS_GAP(CS_GAP)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .length(length),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .busy(busy),
    .done(done), .err(err), .bytes_written(bytes_written),
    .eng_go(eng_go), .eng_tx(eng_tx), .eng_status(eng_status),
    .eng_active(eng_active), .eng_done(eng_done), .cs_n(spi_cs_n)
  );

  aai_spi_byte #(.SCK_DIV(SCK_DIV)) u_spi (
    .clk(clk), .rst_n(rst_n), .go(eng_go), .tx(eng_tx), .rx_lsb(eng_status),
    .active(eng_active), .byte_done(eng_done), .sclk(spi_sclk), .mosi(spi_mosi),
    .miso(spi_miso)
  );

  AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R10
  AST_READY_FRAME_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (spi_cs_n && busy)); // R11
endmodule

// File: tb/aai_flash_writer_test.sv
module aai_flash_writer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEV   = 1024;
  localparam int LIMIT = 6;
  localparam int LW    = 16;
  localparam int BUSYN = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [23:0] start_addr = '0;
  logic [LW-1:0] length = '0;
  logic [7:0] wr_data = '0;
  logic wr_valid = 1'b0, spi_miso = 1'b0;
  logic wr_ready, busy, done, err, spi_cs_n, spi_sclk, spi_mosi;
  logic [LW-1:0] bytes_written;

  always #(CLK_PERIOD / 2) clk = ~clk;

  aai_flash_writer #(
    .LEN_W(LW), .DEV_BYTES(32'(DEV)), .SCK_DIV(2), .POLL_LIMIT(LIMIT), .CS_GAP(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .length(length),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .busy(busy),
    .done(done), .err(err), .bytes_written(bytes_written), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pat(int base, int k);
    return (base + k * 37) & 255;
  endfunction

  // stream source
  int dlen = 0, dbase = 0, didx = 0;
  bit pend = 1'b0;
  always @(negedge clk) begin
    if (pend) didx++;
    wr_valid = didx < dlen;
    wr_data  = 8'(pat(dbase, didx));
    pend     = wr_valid && wr_ready;
  end

  // per-clock protocol watch
  int mode_bad = 0, ready_bad = 0;
  always @(negedge clk) begin
    if (rst_n && spi_cs_n && spi_sclk) mode_bad++;
    if (rst_n && wr_ready && (!busy || !spi_cs_n)) ready_bad++;
  end

  // behavioural flash
  int bitc = 0, busy_left = 0, aai_a = 0;
  int frames_all = 0, busy_polls = 0, cmd_busy = 0;
  logic [7:0] shin = '0, snap = '0;
  bit stuck = 1'b0, wel = 1'b0;
  int fr[$];
  int got[$];
  int exp_q[$];
  int mem[int];

  always @(negedge spi_cs_n) begin
    bitc = 0;
    fr.delete();
  end

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    shin = {shin[6:0], spi_mosi};
    bitc++;
    if (bitc % 8 == 0) begin
      fr.push_back(int'(shin));
      if (bitc == 8 && shin == 8'h05) snap = {6'b0, wel, (stuck || busy_left > 0)};
    end
  end

  always @(negedge spi_sclk) if (!spi_cs_n && bitc >= 8 && bitc < 16) spi_miso = snap[15 - bitc];

  always @(posedge spi_cs_n) if (fr.size() > 0) begin
    frames_all++;
    if (fr[0] == 5) begin
      if (snap[0]) begin
        busy_polls++;
        if (busy_left > 0) busy_left--;
      end
    end else begin
      if (stuck || busy_left > 0) cmd_busy++;
      foreach (fr[i]) got.push_back(fr[i]);
      got.push_back(256);
      if (fr[0] == 6) wel = 1'b1;
      else if (fr[0] == 4) wel = 1'b0;
      else if (fr[0] == 2 && fr.size() == 5) begin
        mem[(fr[1] << 16) | (fr[2] << 8) | fr[3]] = fr[4];
        busy_left = BUSYN;
      end else if (fr[0] == 8'hAD) begin
        if (fr.size() == 6) aai_a = (fr[1] << 16) | (fr[2] << 8) | fr[3];
        mem[aai_a]     = fr[fr.size() - 2];
        mem[aai_a + 1] = fr[fr.size() - 1];
        aai_a += 2;
        busy_left = BUSYN;
      end
    end
  end

  // expected command frames, status reads excluded
  task automatic addr3(input int a);
    exp_q.push_back((a >> 16) & 255);
    exp_q.push_back((a >> 8) & 255);
    exp_q.push_back(a & 255);
  endtask

  task automatic build_exp(input int a0, input int n, input int base);
    int a, r, k;
    bit first;
    exp_q.delete();
    a = a0; r = n; k = 0; first = 1'b1;
    if (n == 0 || a0 + n > DEV) return;
    exp_q.push_back(6); exp_q.push_back(256);                       // R4 enable first
    if (a % 2 == 1) begin                                           // R4 leading byte
      exp_q.push_back(2); addr3(a); exp_q.push_back(pat(base, k)); exp_q.push_back(256);
      a++; r--; k++;
    end
    while (r >= 2) begin                                            // R5 burst
      exp_q.push_back(8'hAD);
      if (first) addr3(a);
      exp_q.push_back(pat(base, k)); exp_q.push_back(pat(base, k + 1)); exp_q.push_back(256);
      first = 1'b0; a += 2; r -= 2; k += 2;
    end
    exp_q.push_back(4); exp_q.push_back(256);                       // R6 close burst
    if (r == 1) begin                                               // R7 trailing byte
      exp_q.push_back(6); exp_q.push_back(256);
      exp_q.push_back(2); addr3(a); exp_q.push_back(pat(base, k)); exp_q.push_back(256);
      exp_q.push_back(4); exp_q.push_back(256);
    end
  endtask

  task automatic run_case(input string tag, input int a, input int n, input int base,
                          input bit stk, input bit exp_err, input int exp_wr);
    int cyc, bad;
    bit ok;
    stuck = stk; got.delete(); mem.delete();
    frames_all = 0; busy_polls = 0; cmd_busy = 0; busy_left = 0; wel = 1'b0;
    dlen = n; dbase = base; didx = 0; pend = 1'b0;
    if (stk) exp_q.delete(); else build_exp(a, n, base);
    @(negedge clk);
    start_addr = 24'(a); length = LW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 30000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done === 1'b1, {tag, " done pulse"}, int'(done), 1);
    chk(err === exp_err, {tag, " err flag"}, int'(err), int'(exp_err));
    chk(int'(bytes_written) == exp_wr, {"R9 ", tag, " bytes_written"}, int'(bytes_written), exp_wr);
    chk(got.size() == exp_q.size(), {tag, " frame byte count"}, got.size(), exp_q.size());
    bad = -1;
    foreach (exp_q[i]) if (bad < 0 && (i >= got.size() || got[i] != exp_q[i])) bad = i;
    if (bad >= 0 && bad < got.size()) chk(1'b0, {tag, " frame content"}, got[bad], exp_q[bad]);
    else chk(bad < 0, {tag, " frame content"}, bad, -1);
    chk(cmd_busy == 0, {"R3 ", tag, " command while busy"}, cmd_busy, 0);
    if (!stk && !exp_err && n > 0) begin
      ok = 1'b1;
      for (int k = 0; k < n; k++) if (!mem.exists(a + k) || mem[a + k] != pat(base, k)) ok = 1'b0;
      chk(ok && mem.num() == n, {"R11 ", tag, " stored data"}, mem.num(), n);
    end
    @(negedge clk);
    chk(!busy && spi_cs_n, {tag, " idle after done"}, int'(busy), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R10 reset SPI idle", int'(spi_sclk), 0);
    chk(busy === 1'b0 && done === 1'b0 && wr_ready === 1'b0, "R11 reset handshake idle", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_case("R1 zero length", 5, 0, 11, 1'b0, 1'b0, 0);
    chk(frames_all == 0, "R1 no SPI traffic", frames_all, 0);
    run_case("R2 overrun by one", 1020, 5, 12, 1'b0, 1'b1, 0);
    chk(frames_all == 0, "R2 no SPI traffic", frames_all, 0);
    run_case("R2 exact boundary", 1020, 4, 13, 1'b0, 1'b0, 4);
    run_case("R5 even start len6", 100, 6, 14, 1'b0, 1'b0, 6);
    run_case("R4 odd start len5", 301, 5, 15, 1'b0, 1'b0, 5);
    run_case("R7 odd start len6", 3, 6, 16, 1'b0, 1'b0, 6);
    run_case("R7 even start len1", 40, 1, 17, 1'b0, 1'b0, 1);
    run_case("R6 odd start len1", 41, 1, 18, 1'b0, 1'b0, 1);
    run_case("R8 stuck busy", 8, 4, 19, 1'b1, 1'b1, 0);
    chk(busy_polls == LIMIT, "R8 busy replies before abort", busy_polls, LIMIT);
    chk(spi_cs_n === 1'b1, "R8 chip select released", int'(spi_cs_n), 1);
    stuck = 1'b0;
    run_case("R3 recovery after timeout", 64, 7, 20, 1'b0, 1'b0, 7);

    chk(mode_bad == 0, "R10 clock high with chip select high", mode_bad, 0);
    chk(ready_bad == 0, "R11 ready outside fetch window", ready_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule